// File: doc/BRIEF.md
# Static-Memory Chip-Select Controller

This block connects an internal request port to one asynchronous 16-bit static device. A request carries a byte address, a direction, a width flag and 32 bits of write data. The block then drives chip select, output enable, write enable, the external address and bank-select pins and the halfword data bus through a fixed sequence of phases: setup, strobe and hold. It has no wait input. A 32-bit configuration word gives the length of every phase, a read-to-write gap, the chip-select style and the bus size.

When the bus size code selects a 16-bit bus, a 32-bit request becomes two back-to-back halfword transfers with no further handshake from the requester. Read halves are joined into one 32-bit result. The configuration word is sampled when a request is accepted. `req_ready` pulses once, when the whole transfer is finished.

Top module: `async_mem_ctrl`

## Requirements
- R1: During and after reset, with no request, `cs_n`, `oe_n` and `we_n` are high and `dq_oe` and `req_ready` are low.
- R2: Configuration word fields: bit 31 is chip-select style (1 = select-strobe), [29:26] write setup, [25:20] write strobe, [19:17] write hold, [16:13] read setup, [12:7] read strobe, [6:4] read hold, [3:2] read-to-write gap, [1:0] bus size code. The word is sampled in the cycle the request is accepted.
- R3: Each phase lasts its field value plus one cycles, with no stretching. The first setup cycle starts on the clock edge that accepts the request.
- R4: With bit 31 = 0, `cs_n` is low through setup, strobe and hold of every transfer. With bit 31 = 1, `cs_n` is low only in the strobe phase.
- R5: `ext_addr` carries byte address bits [AW-1:2], so byte bit 17 appears on `ext_addr[15]`. It is stable while `cs_n` stays low. For a single transfer, `ext_ba` carries byte address bits [1:0].
- R6: When the size code is 1 and `req_wide` is 1, two halfword transfers are made. The first uses `ext_ba` = 2'b00 and `req_wdata[15:0]`. The second uses `ext_ba` = 2'b10 and `req_wdata[31:16]`. No gap is inserted between them.
- R7: A request with `req_wide` = 0, or any request when the size code is not 1, makes one transfer using the lower halfword. A read then returns zero in `req_rdata[31:16]`.
- R8: Read data is taken from `dq_in` in the last strobe cycle of each halfword. The first halfword fills `req_rdata[15:0]` and the second fills `req_rdata[31:16]`.
- R9: A write accepted right after a read first waits for as many idle cycles as the gap field holds (0 means none), with all strobes and `cs_n` high. A read is never delayed by this gap, and neither is a write that follows a write.
- R10: `req_ready` is high for exactly one cycle, the cycle after the last hold cycle. A new request is accepted only when the block is idle and `req_ready` is low.
- R11: `oe_n` is low exactly in read strobe cycles and `we_n` is low exactly in write strobe cycles. `dq_oe` is high through the setup, strobe and hold of a write and never while `oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg | input | 32 | Timing and mode word |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit request, 0 = 16-bit |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read result, valid with `req_ready` |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| ext_addr | output | AW-2 | External address pins |
| ext_ba | output | 2 | Bank-select pins |
| dq_out | output | 16 | Data driven to the device |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 16 | Data returned by the device |

## Verification
The first setup cycle starts on the accepting edge. The bench therefore samples at each falling edge after that edge. It steps through the optional gap cycles and then the setup, strobe and hold cycles of each halfword, in counts taken from the configuration word plus one. `req_ready` and `req_rdata` are checked on the falling edge after the last hold cycle, and `req_ready` is checked low one cycle later. A bench model returns halfword data as a function of `ext_addr` and `ext_ba`, so the expected read word follows from the request address alone.

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_wide,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          req_ready,
  output logic [31:0]   req_rdata,
  output logic          cs_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [AW-3:0] ext_addr,
  output logic [1:0]    ext_ba,
  output logic [15:0]   dq_out,
  output logic          dq_oe,
  input  logic [15:0]   dq_in
);
  typedef enum logic [2:0] {IDLE, TURN, SETUP, STROBE, HOLD} st_t;

  st_t          st;
  logic [5:0]   cnt;
  logic [31:0]  c, d, rdat;
  logic [AW-1:0] a;
  logic         wr, split, half, prev_rd, rdy;
  logic         unused_bits;

  wire acc = (st == IDLE) && req_valid && !rdy;
  wire [5:0] n_setup  = wr ? {2'b0, c[29:26]} : {2'b0, c[16:13]};
  wire [5:0] n_strobe = wr ? c[25:20] : c[12:7];
  wire [5:0] n_hold   = wr ? {3'b0, c[19:17]} : {3'b0, c[6:4]};
  wire [5:0] a_setup  = req_write ? {2'b0, cfg[29:26]} : {2'b0, cfg[16:13]};
  wire       busy     = (st == SETUP) || (st == STROBE) || (st == HOLD);

  assign unused_bits = ^{c[30], c[3:0], cfg[30]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; c <= '0; d <= '0; rdat <= '0; a <= '0;
      wr <= 1'b0; split <= 1'b0; half <= 1'b0; prev_rd <= 1'b0; rdy <= 1'b0;
    end else begin
      rdy <= 1'b0;
      unique case (st)
        IDLE: if (acc) begin
          c <= cfg; wr <= req_write; a <= req_addr; d <= req_wdata;
          split <= req_wide && (cfg[1:0] == 2'd1);
          half <= 1'b0; rdat <= '0;
          if (req_write && prev_rd && cfg[3:2] != 2'd0) begin
            st <= TURN; cnt <= {4'b0, cfg[3:2] - 2'd1};
          end else begin
            st <= SETUP; cnt <= a_setup;
          end
        end
        TURN:
          if (cnt == 0) begin st <= SETUP; cnt <= n_setup; end
          else cnt <= cnt - 6'd1;
        SETUP:
          if (cnt == 0) begin st <= STROBE; cnt <= n_strobe; end
          else cnt <= cnt - 6'd1;
        STROBE:
          if (cnt == 0) begin
            if (!wr) begin
              if (half) rdat[31:16] <= dq_in;
              else      rdat[15:0]  <= dq_in;
            end
            st <= HOLD; cnt <= n_hold;
          end else cnt <= cnt - 6'd1;
        HOLD:
          if (cnt != 0) cnt <= cnt - 6'd1;
          else if (split && !half) begin
            half <= 1'b1; st <= SETUP; cnt <= n_setup;
          end else begin
            st <= IDLE; rdy <= 1'b1; prev_rd <= !wr;
          end
        default: st <= IDLE;
      endcase
    end
  end

  assign cs_n      = !((st == STROBE) || (!c[31] && busy));
  assign oe_n      = !((st == STROBE) && !wr);
  assign we_n      = !((st == STROBE) && wr);
  assign dq_oe     = wr && busy;
  assign dq_out    = half ? d[31:16] : d[15:0];
  assign ext_addr  = a[AW-1:2];
  assign ext_ba    = split ? {half, 1'b0} : a[1:0];
  assign req_ready = rdy;
  assign req_rdata = rdat;

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  p_no_drive_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);
  p_strobe_has_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> !cs_n);
  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(ext_addr));
endmodule

// File: tb/async_mem_ctrl_tb_top.sv
module async_mem_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg = '0, req_wdata = '0, req_rdata;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [23:0] req_addr = '0;
  logic req_ready, cs_n, oe_n, we_n, dq_oe;
  logic [21:0] ext_addr;
  logic [1:0] ext_ba;
  logic [15:0] dq_out, dq_in;
  int n_chk = 0, n_bad = 0;
  bit last_rd = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [15:0] mem_f(logic [21:0] ea, logic [1:0] ba);
    return 16'hA5C3 ^ {ba, ea[13:0]};
  endfunction
  assign dq_in = mem_f(ext_addr, ext_ba);

  async_mem_ctrl #(.AW(24)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .req_valid(req_valid),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .ext_addr(ext_addr),
    .ext_ba(ext_ba), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  function automatic logic [31:0] mkcfg(bit ss, int ws, int wst, int wh,
                                        int rs, int rst, int rh, int ta, int asz);
    return {ss, 1'b0, 4'(ws), 6'(wst), 3'(wh), 4'(rs), 6'(rst), 3'(rh), 2'(ta), 2'(asz)};
  endfunction

  localparam logic [89:0] VEC [8] = '{
    {mkcfg(0,0,0,0,1,2,0,0,1), 1'b0, 1'b1, 24'h020004, 32'h0},
    {mkcfg(0,0,1,1,0,0,0,2,1), 1'b1, 1'b1, 24'h000100, 32'hCAFE1234},
    {mkcfg(0,1,0,2,0,0,0,2,1), 1'b1, 1'b0, 24'h00030F, 32'h0000BEEF},
    {mkcfg(1,0,0,0,2,1,1,0,1), 1'b0, 1'b0, 24'h123456, 32'h0},
    {mkcfg(1,1,2,1,0,0,0,3,1), 1'b1, 1'b1, 24'h000040, 32'h89ABCDEF},
    {mkcfg(0,0,0,0,0,1,0,0,2), 1'b0, 1'b1, 24'h00A00C, 32'h0},
    {mkcfg(0,0,0,0,0,0,1,3,1), 1'b0, 1'b1, 24'h0FFFF8, 32'h0},
    {mkcfg(0,0,0,0,0,0,0,0,1), 1'b1, 1'b1, 24'h000020, 32'h55AA33CC}
  };

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [89:0] v);
    logic [31:0] c = v[89:58];
    logic [31:0] wd = v[31:0];
    logic [23:0] ad = v[55:32];
    bit wr = v[57];
    bit sp = v[56] && (c[1:0] == 2'd1);
    int nh = sp ? 2 : 1;
    int nt = (wr && last_rd) ? int'(c[3:2]) : 0;
    int bad = 0;
    logic [31:0] exp_rd;
    @(negedge clk);
    cfg = c; req_write = wr; req_wide = v[56]; req_addr = ad; req_wdata = wd;
    req_valid = 1'b1;
    for (int i = 0; i < nt; i++) begin
      @(negedge clk); req_valid = 1'b0;
      if (cs_n !== 1'b1 || oe_n !== 1'b1 || we_n !== 1'b1) bad++;
    end
    for (int hf = 0; hf < nh; hf++) begin
      for (int p = 0; p < 3; p++) begin
        int n = (p == 0) ? int'(wr ? c[29:26] : c[16:13]) :
                (p == 1) ? int'(wr ? c[25:20] : c[12:7]) :
                           int'(wr ? c[19:17] : c[6:4]);
        for (int i = 0; i <= n; i++) begin
          @(negedge clk); req_valid = 1'b0;
          if (cs_n !== (c[31] && p != 1)) bad++;
          if (oe_n !== !(p == 1 && !wr)) bad++;
          if (we_n !== !(p == 1 && wr)) bad++;
          if (dq_oe !== wr) bad++;
          if (ext_addr !== ad[23:2]) bad++;
          if (ext_ba !== (sp ? {hf[0], 1'b0} : ad[1:0])) bad++;
          if (wr && dq_out !== (hf == 1 ? wd[31:16] : wd[15:0])) bad++;
          if (req_ready !== 1'b0) bad++;
        end
      end
    end
    chk(bad == 0, "R2 R3 R4 R5 R6 R9 R11 phase sequence", bad, 0);
    @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready after last hold", req_ready, 1);
    if (!wr) begin
      exp_rd = sp ? {mem_f(ad[23:2], 2'b10), mem_f(ad[23:2], 2'b00)}
                  : {16'h0, mem_f(ad[23:2], ad[1:0])};
      chk(req_rdata === exp_rd, "R6 R7 R8 read result", req_rdata, exp_rd);
    end
    last_rd = !wr;
    @(negedge clk);
    chk(req_ready === 1'b0, "R10 ready lasts one cycle", req_ready, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && oe_n === 1'b1 && we_n === 1'b1 && dq_oe === 1'b0 && req_ready === 1'b0,
        "R1 outputs in reset", {cs_n, oe_n, we_n, dq_oe, req_ready}, 32'h1C);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n === 1'b1 && oe_n === 1'b1 && we_n === 1'b1 && dq_oe === 1'b0 && req_ready === 1'b0,
        "R1 idle after reset", {cs_n, oe_n, we_n, dq_oe, req_ready}, 32'h1C);
    foreach (VEC[k]) run(VEC[k]);
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && req_ready === 1'b0, "R10 no restart without request",
        {cs_n, req_ready}, 32'h2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule